// File: doc/BRIEF.md
# Synchronous SRAM byte-write controller

This block is the clocked front end of a pipelined synchronous memory that supports per-byte writes. At every rising clock edge it samples two active-low address strobes (one for a host processor, one for a memory controller), a chip select, a whole-word write enable, a lane-write enable and one active-low select per byte lane. From these it classifies the cycle as idle, deselect, read or write, and updates the addressed word of an internal array one lane at a time.

A host-strobe cycle always reads. A write can happen only on a later clock of the same access with no strobe asserted, or on a cycle opened by the controller strobe. Read data passes through an output register. The output enable is asynchronous. The tri-state data bus is modelled as a registered data word plus a drive-enable that the output enable gates combinationally. That drive-enable is forced low whenever the present clock is a write.

Top module: `sram_bw_ctrl`

## Requirements
- R1: A clock edge with `host_strb_n` low and `sel_n` low is a read of `addr`, whatever `wr_all_n`, `wr_lanes_n` and `lane_sel_n` show. The host strobe takes priority over the controller strobe.
- R2: Writes happen only in two cases. The first is a `ctl_strb_n` edge with `sel_n` low, which writes to `addr`. The second is an edge with both strobes high during an open access, which writes to the address latched by the last selecting strobe. With no open access and no strobe, an edge does nothing.
- R3: With `wr_all_n` low, all four lanes of the word are written from `wdata`, and `wr_lanes_n` and `lane_sel_n` are ignored.
- R4: With `wr_all_n` high and `wr_lanes_n` high, the cycle is a read for every value of `lane_sel_n`.
- R5: With `wr_all_n` high and `wr_lanes_n` low, lane i (bits 8i+7..8i of the word and of `wdata`) is written when `lane_sel_n[i]` is 0. Lanes whose select is 1 keep their old contents.
- R6: With `wr_all_n` high, `wr_lanes_n` low and `lane_sel_n` = 4'b1111, the cycle is a read.
- R7: `out_en_n` is not clocked. A change on it reaches `rdata_oe` within the same clock cycle, and `rdata_oe` is low whenever `out_en_n` is high.
- R8: `rdata_oe` is low while the current clock's controls form a write. Read data still pending when a write edge occurs is dropped and is not driven afterwards.
- R9: A strobe edge with `sel_n` high is a deselect. It performs no read or write and closes the open access, so later strobe-free edges do nothing and the bus is released.
- R10: A read whose address is registered at edge T presents the word on `rdata` after edge T+1. `rdata_oe` is high from T+1 until the next edge while `out_en_n` is low and no write is being formed.
- R11: While `rst` is high and after it falls, no access is open and `rdata_oe` is low until a read has passed through the pipeline. Array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select, sampled on strobe edges |
| host_strb_n | input | 1 | Active-low host address strobe (always a read) |
| ctl_strb_n | input | 1 | Active-low controller address strobe |
| wr_all_n | input | 1 | Active-low whole-word write |
| wr_lanes_n | input | 1 | Active-low lane-write enable |
| lane_sel_n | input | 4 | Active-low per-lane write selects, bit i for bits 8i+7..8i |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 32 | Registered read data |
| rdata_oe | output | 1 | Bus drive enable for `rdata` |

## Verification
The hardest situation to reach is a read word still in the output pipeline at the moment a strobe-free write clock arrives. Observing that the drive is masked at once, the pending word is dropped, and only the selected lanes change requires a host-strobe read, then a write on the very next clock, then a re-read of the same word. The directed stimulus builds this chain explicitly at several lane-select patterns. It also toggles the output enable between clock edges to observe its asynchronous effect. A long weighted random phase then mixes strobes, deselects and partial writes against a bench array that is compared on every clock.

// File: rtl/sram_bw_pkg.sv
package sram_bw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_DESEL = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } sram_op_e;
endpackage

// File: rtl/sram_bw_decode.sv
// Write-control decode: per-lane enables from word/lane controls.
module sram_bw_decode #(
  parameter int LANES = 4
) (
  input  logic             wr_all_n,
  input  logic             wr_lanes_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_we,
  output logic             is_write
);
  always_comb begin
    lane_we = '0;
    if (!wr_all_n)
      lane_we = '1;
    else if (!wr_lanes_n)
      lane_we = ~lane_sel_n;
    is_write = |lane_we;
  end
endmodule

// File: rtl/sram_bw_seq.sv
// Access sequencer: classifies each edge and holds the open-access address.
module sram_bw_seq
  import sram_bw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              host_strb_n,
  input  logic              ctl_strb_n,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  output sram_op_e          op,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              active_q
);
  logic              strobe;
  logic [ADDR_W-1:0] addr_q;

  assign strobe = !host_strb_n || !ctl_strb_n;

  always_comb begin
    op       = OP_IDLE;
    acc_addr = addr_q;
    if (strobe) begin
      acc_addr = addr;
      if (sel_n)
        op = OP_DESEL;
      else if (!host_strb_n)
        op = OP_READ;
      else
        op = is_write ? OP_WRITE : OP_READ;
    end else if (active_q) begin
      op = is_write ? OP_WRITE : OP_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      addr_q   <= '0;
    end else if (strobe) begin
      active_q <= !sel_n;
      if (!sel_n)
        addr_q <= addr;
    end
  end

  // R9: a deselecting strobe closes the access
  a_r9_desel_closes: assert property (@(posedge clk) disable iff (rst)
    (strobe && sel_n) |=> !active_q);

  // R2: a selecting strobe opens an access
  a_r2_strobe_opens: assert property (@(posedge clk) disable iff (rst)
    (strobe && !sel_n) |=> active_q);
endmodule

// File: rtl/sram_bw_lane.sv
// One byte lane of the array: write port plus registered read port.
module sram_bw_lane #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/sram_bw_bus.sv
// Output stage: read-data valid tracking and asynchronous drive gating.
module sram_bw_bus (
  input  logic clk,
  input  logic rst,
  input  logic rd_issue_q,
  input  logic wr_now,
  input  logic out_en_n,
  output logic rd_valid_q,
  output logic drive
);
  always_ff @(posedge clk) begin
    if (rst)
      rd_valid_q <= 1'b0;
    else
      rd_valid_q <= rd_issue_q && !wr_now;
  end

  assign drive = rd_valid_q && !out_en_n && !wr_now;

  // R7: enable high never drives
  a_r7_oe_blocks: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !drive);
endmodule

// File: rtl/sram_bw_ctrl.sv
// Top: synchronous SRAM front end with byte-lane writes.
module sram_bw_ctrl
  import sram_bw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sel_n,
  input  logic                    host_strb_n,
  input  logic                    ctl_strb_n,
  input  logic                    wr_all_n,
  input  logic                    wr_lanes_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int WORD_W = LANES * LANE_W;

  logic [LANES-1:0]  lane_we;
  logic              is_write;
  sram_op_e          op;
  logic [ADDR_W-1:0] acc_addr;
  logic              active_q;
  logic              wr_now;
  logic [LANES-1:0]  mem_we;
  logic              rd_issue_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_valid_q;
  logic [WORD_W-1:0] word_q;

  sram_bw_decode #(.LANES(LANES)) dec_i (
    .wr_all_n  (wr_all_n),
    .wr_lanes_n(wr_lanes_n),
    .lane_sel_n(lane_sel_n),
    .lane_we   (lane_we),
    .is_write  (is_write)
  );

  sram_bw_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .sel_n      (sel_n),
    .host_strb_n(host_strb_n),
    .ctl_strb_n (ctl_strb_n),
    .is_write   (is_write),
    .addr       (addr),
    .op         (op),
    .acc_addr   (acc_addr),
    .active_q   (active_q)
  );

  assign wr_now = (op == OP_WRITE);
  assign mem_we = wr_now ? lane_we : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_issue_q <= 1'b0;
      rd_addr_q  <= '0;
    end else begin
      rd_issue_q <= (op == OP_READ);
      if (op == OP_READ)
        rd_addr_q <= acc_addr;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_bw_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) lane_i (
      .clk  (clk),
      .we   (mem_we[g]),
      .waddr(acc_addr),
      .wdata(wdata[g*LANE_W +: LANE_W]),
      .re   (rd_issue_q),
      .raddr(rd_addr_q),
      .rdata(word_q[g*LANE_W +: LANE_W])
    );
  end

  sram_bw_bus bus_i (
    .clk       (clk),
    .rst       (rst),
    .rd_issue_q(rd_issue_q),
    .wr_now    (wr_now),
    .out_en_n  (out_en_n),
    .rd_valid_q(rd_valid_q),
    .drive     (rdata_oe)
  );

  assign rdata = word_q;

  // R1: host strobe never writes
  a_r1_host_reads: assert property (@(posedge clk) disable iff (rst)
    !host_strb_n |-> (mem_we == '0));

  // R2: no strobe and no open access -> no write
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (host_strb_n && ctl_strb_n && !active_q) |-> (mem_we == '0));

  // R3: whole-word write touches every lane
  a_r3_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (!wr_all_n && wr_now) |-> ($countones(mem_we) == LANES));

  // R6: lane enable with no lane selected is a read
  a_r6_empty_sel_reads: assert property (@(posedge clk) disable iff (rst)
    (wr_all_n && !wr_lanes_n && (&lane_sel_n)) |-> (mem_we == '0));

  // R8: a write edge drops pending read data
  a_r8_write_drops: assert property (@(posedge clk) disable iff (rst)
    wr_now |=> !rd_valid_q);

  // R10: read issued, no write next edge -> data valid after that edge
  a_r10_pipe: assert property (@(posedge clk) disable iff (rst)
    (op == OP_READ) ##1 !wr_now |=> rd_valid_q);
endmodule

// File: tb/sram_bw_ctrl_tb_top.sv
module sram_bw_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1;
  logic        host_strb_n = 1'b1;
  logic        ctl_strb_n = 1'b1;
  logic        wr_all_n = 1'b1;
  logic        wr_lanes_n = 1'b1;
  logic [3:0]  lane_sel_n = 4'hF;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        out_en_n = 1'b1;
  logic [31:0] rdata;
  logic        rdata_oe;

  int    n_tests = 0;
  int    n_fail = 0;
  string cur_req = "R11";

  always #4 clk = ~clk;

  sram_bw_ctrl dut_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .host_strb_n(host_strb_n),
    .ctl_strb_n(ctl_strb_n), .wr_all_n(wr_all_n), .wr_lanes_n(wr_lanes_n),
    .lane_sel_n(lane_sel_n), .addr(addr), .wdata(wdata), .out_en_n(out_en_n),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // Reference model state
  logic [31:0] m_mem [256];
  logic        m_active = 1'b0;
  logic [7:0]  m_addr = '0;
  logic        m_iss = 1'b0;
  logic [7:0]  m_raddr = '0;
  logic        m_valid = 1'b0;
  logic [31:0] m_data = '0;

  function automatic logic [3:0] lanes_of();
    if (!wr_all_n) return 4'hF;
    if (!wr_lanes_n) return ~lane_sel_n;
    return 4'h0;
  endfunction

  // 0 idle, 1 deselect, 2 read, 3 write
  function automatic int op_of();
    if (!host_strb_n || !ctl_strb_n) begin
      if (sel_n) return 1;
      if (!host_strb_n) return 2;
      return (lanes_of() != 0) ? 3 : 2;
    end
    if (m_active) return (lanes_of() != 0) ? 3 : 2;
    return 0;
  endfunction

  always @(posedge clk) begin : model
    int         op;
    logic [7:0] a;
    logic [3:0] we;
    if (rst) begin
      m_active = 1'b0;
      m_iss    = 1'b0;
      m_valid  = 1'b0;
    end else begin
      op = op_of();
      we = lanes_of();
      a  = (!host_strb_n || !ctl_strb_n) ? addr : m_addr;
      if (m_iss) m_data = m_mem[m_raddr];
      m_valid = m_iss && (op != 3);
      if (op == 3)
        for (int i = 0; i < 4; i++)
          if (we[i]) m_mem[a][8*i +: 8] = wdata[8*i +: 8];
      m_iss = (op == 2);
      if (op == 2) m_raddr = a;
      if (!host_strb_n || !ctl_strb_n) begin
        m_active = !sel_n;
        if (!sel_n) m_addr = addr;
      end
    end
  end

  task automatic check(input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin : cmp
    logic exp_oe;
    exp_oe = !rst && m_valid && !out_en_n && (op_of() != 3);
    check(rdata_oe === exp_oe, "rdata_oe", {31'd0, rdata_oe}, {31'd0, exp_oe});
    if (exp_oe)
      check(rdata === m_data, "rdata", rdata, m_data);
  end

  task automatic drive(input logic hs, input logic cs, input logic sl,
                       input logic wa, input logic wl, input logic [3:0] ls,
                       input logic [7:0] a, input logic [31:0] d,
                       input logic oe, input string req);
    @(posedge clk); #1;
    host_strb_n = hs; ctl_strb_n = cs; sel_n = sl;
    wr_all_n = wa; wr_lanes_n = wl; lane_sel_n = ls;
    addr = a; wdata = d; out_en_n = oe; cur_req = req;
  endtask

  // Read with host strobe, then one strobe-free clock to see data
  task automatic host_read(input logic [7:0] a, input string req);
    drive(0, 1, 0, 1, 1, 4'hF, a, 32'h0, 0, req);
    drive(1, 1, 0, 1, 1, 4'hF, a, 32'h0, 0, req);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    check(rdata_oe === 1'b0, "R11 oe in reset", {31'd0, rdata_oe}, 32'd0);
    rst = 1'b0;
    // Fill the array with whole-word writes under the controller strobe (R3)
    for (int i = 0; i < 256; i++)
      drive(1, 0, 0, 0, 1, 4'hF, 8'(i), {8'(i), 8'hA5, 8'(~i), 8'h3C}, 1, "R3");

    // R1: host strobe with every write control active still reads
    drive(0, 1, 0, 0, 0, 4'h0, 8'd5, 32'hDEADBEEF, 0, "R1");
    drive(1, 1, 0, 1, 1, 4'hF, 8'd5, 32'h0, 0, "R10");
    drive(1, 1, 0, 1, 1, 4'hF, 8'd5, 32'h0, 0, "R10");

    // R5/R8: read pending then partial write on next clock
    drive(0, 1, 0, 1, 1, 4'hF, 8'd9, 32'h0, 0, "R8");
    drive(1, 1, 0, 1, 0, 4'b1010, 8'd0, 32'h11223344, 0, "R5");
    drive(1, 1, 0, 1, 1, 4'hF, 8'd0, 32'h0, 0, "R8");
    host_read(8'd9, "R5");
    drive(0, 1, 0, 1, 1, 4'hF, 8'd9, 32'h0, 0, "R8");
    drive(1, 1, 0, 1, 0, 4'b0111, 8'd0, 32'hCAFEF00D, 0, "R5");
    host_read(8'd9, "R5");

    // R4: lane enable high, selects all low -> read
    drive(1, 1, 0, 1, 1, 4'h0, 8'd0, 32'hFFFFFFFF, 0, "R4");
    drive(1, 1, 0, 1, 1, 4'h0, 8'd0, 32'hFFFFFFFF, 0, "R4");
    // R6: lane enable low, no lane selected -> read
    drive(1, 1, 0, 1, 0, 4'hF, 8'd0, 32'hFFFFFFFF, 0, "R6");
    drive(1, 1, 0, 1, 0, 4'hF, 8'd0, 32'hFFFFFFFF, 0, "R6");
    host_read(8'd9, "R4");

    // R7: asynchronous output enable
    host_read(8'd20, "R7");
    @(negedge clk); #1;
    out_en_n = 1'b1; #1;
    check(rdata_oe === 1'b0, "R7 async off", {31'd0, rdata_oe}, 32'd0);
    out_en_n = 1'b0; #1;
    check(rdata_oe === 1'b1, "R7 async on", {31'd0, rdata_oe}, 32'd1);
    drive(1, 1, 0, 1, 1, 4'hF, 8'd20, 32'h0, 1, "R7");

    // R9: deselect with write controls active, then strobe-free write attempt
    drive(1, 0, 1, 0, 1, 4'h0, 8'd30, 32'h0BADF00D, 0, "R9");
    drive(1, 1, 0, 0, 1, 4'h0, 8'd30, 32'h0BADF00D, 0, "R9");
    drive(1, 1, 0, 1, 1, 4'hF, 8'd30, 32'h0, 0, "R9");
    host_read(8'd30, "R9");
    drive(0, 1, 1, 1, 1, 4'hF, 8'd30, 32'h0, 0, "R9");
    drive(1, 1, 0, 1, 1, 4'hF, 8'd30, 32'h0, 0, "R9");

    // R2: controller strobe write, followed by strobe-free lane write
    drive(1, 0, 0, 1, 0, 4'b1110, 8'd40, 32'h000000EE, 0, "R2");
    drive(1, 1, 0, 1, 0, 4'b1101, 8'd0, 32'h0000DD00, 0, "R2");
    host_read(8'd40, "R2");

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[2:0] == 0 ? 1'b0 : 1'b1, r[5:3] == 0 ? 1'b0 : 1'b1,
            r[9:6] == 0 ? 1'b1 : 1'b0, r[12:10] != 0 ? 1'b1 : 1'b0,
            r[13], r[17:14], {4'd0, r[21:18]}, $urandom,
            r[24:22] == 0 ? 1'b1 : 1'b0, "R5");
    end
    drive(1, 1, 1, 1, 1, 4'hF, 8'd0, 32'h0, 1, "R2");
    repeat (2) @(posedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule